// File: doc/BRIEF.md
# Quick-Channel DMA Trigger Mapper

This block holds a small parameter RAM made of 32-byte slots, each slot being eight 32-bit words. It also runs eight quick channels. Each channel points at one word of one slot. When an ordinary bus write lands on that word and the channel is enabled, the block raises a transfer event. No separate start bit is needed. Software writes a full transfer descriptor into a slot, maps a channel to the word it writes last, and enables the channel. The final descriptor write then starts the transfer.

Each event becomes a request to a transfer engine. The request carries the channel number and the slot that was hit. The engine later reports a 6-bit completion code. That code sets one bit of a 64-bit interrupt-pending register, which software reads and clears in two 32-bit halves.

Each channel keeps a secondary-event flag while its request is outstanding. A trigger that arrives while that flag is set is not lost silently. It sets a missed-event flag for the channel instead. All flags are cleared by writing 1 to the matching bit of a clear register.

Top module: `qdma_trigger_map`

## Requirements
- R1: After reset, these all read 0: every map register, the enable mask, the secondary-event flags, the missed-event flags and both pending halves. `req_valid` is low.
- R2: Channel n has a map register at byte address 0x200+4n. Bits 13:5 hold the slot number and bits 4:2 hold the word index. A read returns only those fields, with every other bit 0.
- R3: Word w of slot N sits at byte address 0x4000+32N+4w. For implemented slots (N < PSLOTS) a write stores the data and a read returns it.
- R4: Writing 1 to bit n at 0x108C enables channel n. Writing 1 to bit n at 0x1088 disables it. The enable mask reads at 0x1080. Bits written as 0 change nothing.
- R5: A write to the slot and word mapped by an enabled channel raises `req_valid` in the following cycle, with `req_chan` = the channel and `req_slot` = the slot. A write to any other word, or to the mapped word of a disabled channel, raises no request.
- R6: A trigger sets the channel's secondary-event flag, readable at 0x1090. The flag clears when the engine accepts the request (`req_valid` and `req_ready` high at a clock edge), or when 1 is written to its bit at 0x1094.
- R7: A trigger on a channel whose secondary-event flag is still set sets that channel's missed-event flag, readable at 0x0310, and issues no second request. Writing 1 to bit n at 0x0314 clears that flag. Writing 0 leaves it set.
- R8: When several channels have requests pending, the lowest-numbered one is offered first. Once offered, a request stays offered unchanged until it is accepted.
- R9: A completion with code c < 32 sets bit c of the low pending half at 0x1068. A code from 32 to 63 sets bit c−32 of the high half at 0x106C.
- R10: Writing 1 to a bit at 0x1070 clears that bit of the low half, and 0x1074 does the same for the high half. If a completion sets a bit in the same cycle that a write clears it, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 16 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 16 | Byte address of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| req_valid | output | 1 | Transfer request offered to the engine |
| req_ready | input | 1 | Engine accepts the offered request |
| req_chan | output | 3 | Channel of the offered request |
| req_slot | output | 9 | Slot that triggered the offered request |
| cpl_valid | input | 1 | Completion strobe from the engine |
| cpl_code | input | 6 | Completion code |

## Verification
A map register holding the wrong value shows up in one of two ways. Either the write to the intended word raises no request, or a write to a neighbouring word raises one. Both are visible on `req_valid` in the cycle right after the write. A corrupted secondary-event flag shows up as a missing request or a duplicate request at the next acceptance, and the scoreboard catches both. A corrupted missed-event flag or pending bit appears only when its register is read. For that reason each flag is read back immediately after every stimulus that can set it or clear it, including writes of zero and a completion that lands in the same cycle as a clear.

// File: rtl/qdma_trigger_map.sv
module qdma_trigger_map #(
  parameter int CHANNELS = 8,
  parameter int PSLOTS   = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [15:0]                 wr_addr,
  input  logic [31:0]                 wr_data,
  input  logic [15:0]                 rd_addr,
  output logic [31:0]                 rd_data,
  output logic                        req_valid,
  input  logic                        req_ready,
  output logic [$clog2(CHANNELS)-1:0] req_chan,
  output logic [8:0]                  req_slot,
  input  logic                        cpl_valid,
  input  logic [5:0]                  cpl_code
);
  localparam int CW = $clog2(CHANNELS);
  localparam int SW = $clog2(PSLOTS);
  localparam int WORDS = PSLOTS * 8;

  localparam logic [15:0] MAP_BASE = 16'h0200;
  localparam logic [15:0] MISS_RD  = 16'h0310;
  localparam logic [15:0] MISS_CLR = 16'h0314;
  localparam logic [15:0] PEND_LO  = 16'h1068;
  localparam logic [15:0] PEND_HI  = 16'h106C;
  localparam logic [15:0] PCLR_LO  = 16'h1070;
  localparam logic [15:0] PCLR_HI  = 16'h1074;
  localparam logic [15:0] EN_RD    = 16'h1080;
  localparam logic [15:0] EN_CLR   = 16'h1088;
  localparam logic [15:0] EN_SET   = 16'h108C;
  localparam logic [15:0] SEC_RD   = 16'h1090;
  localparam logic [15:0] SEC_CLR  = 16'h1094;

  logic [8:0]          map_slot [CHANNELS];
  logic [2:0]          map_word [CHANNELS];
  logic [8:0]          ev_slot  [CHANNELS];
  logic [31:0]         pram     [WORDS];
  logic [CHANNELS-1:0] en, sec, miss, hit, grant;
  logic [63:0]         pend;
  logic [CW-1:0]       low, cur, hold_ch;
  logic                hold_q;

  function automatic logic sel(input logic [15:0] a);
    return wr_en && (wr_addr == a);
  endfunction

  wire                wr_pram = wr_en && (wr_addr[15:14] == 2'b01);
  wire [8:0]          wr_slot = wr_addr[13:5];
  wire [2:0]          wr_word = wr_addr[4:2];
  wire [CHANNELS-1:0] wmask   = wr_data[CHANNELS-1:0];
  wire [CHANNELS-1:0] en_set  = sel(EN_SET)   ? wmask : '0;
  wire [CHANNELS-1:0] en_clr  = sel(EN_CLR)   ? wmask : '0;
  wire [CHANNELS-1:0] sec_clr = sel(SEC_CLR)  ? wmask : '0;
  wire [CHANNELS-1:0] mis_clr = sel(MISS_CLR) ? wmask : '0;
  wire [63:0] pend_clr = {sel(PCLR_HI) ? wr_data : 32'h0, sel(PCLR_LO) ? wr_data : 32'h0};
  wire [63:0] pend_set = cpl_valid ? (64'd1 << cpl_code) : 64'd0;

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_ch
    localparam logic [15:0] MAP_ADDR = MAP_BASE + 16'(ch * 4);
    assign hit[ch] = wr_pram && en[ch] && (wr_slot == map_slot[ch]) && (wr_word == map_word[ch]);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        map_slot[ch] <= '0;
        map_word[ch] <= '0;
        ev_slot[ch]  <= '0;
      end else begin
        if (sel(MAP_ADDR)) begin
          map_slot[ch] <= wr_data[13:5];
          map_word[ch] <= wr_data[4:2];
        end
        if (hit[ch] && !sec[ch]) ev_slot[ch] <= wr_slot;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_pram && (int'(wr_slot) < PSLOTS))
      pram[wr_addr[SW+4:2]] <= wr_data;
  end

  always_comb begin
    low = '0;
    for (int i = CHANNELS - 1; i >= 0; i--)
      if (sec[i]) low = CW'(i);
  end

  assign cur       = hold_q ? hold_ch : low;
  assign req_valid = sec[cur];
  assign req_chan  = cur;
  assign req_slot  = ev_slot[cur];

  always_comb begin
    grant = '0;
    if (req_valid && req_ready) grant[cur] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en      <= '0;
      sec     <= '0;
      miss    <= '0;
      pend    <= '0;
      hold_q  <= 1'b0;
      hold_ch <= '0;
    end else begin
      en      <= (en | en_set) & ~en_clr;
      sec     <= (sec & ~grant & ~sec_clr) | (hit & ~sec);
      miss    <= (miss & ~mis_clr) | (hit & sec);
      pend    <= (pend & ~pend_clr) | pend_set;
      hold_q  <= req_valid && !req_ready;
      hold_ch <= cur;
    end
  end

  always_comb begin
    rd_data = 32'h0;
    case (rd_addr)
      MISS_RD: rd_data[CHANNELS-1:0] = miss;
      PEND_LO: rd_data = pend[31:0];
      PEND_HI: rd_data = pend[63:32];
      EN_RD:   rd_data[CHANNELS-1:0] = en;
      SEC_RD:  rd_data[CHANNELS-1:0] = sec;
      default: begin
        for (int i = 0; i < CHANNELS; i++)
          if (rd_addr == MAP_BASE + 16'(i * 4))
            rd_data = {18'h0, map_slot[i], map_word[i], 2'b00};
        if (rd_addr[15:14] == 2'b01 && int'(rd_addr[13:5]) < PSLOTS)
          rd_data = pram[rd_addr[SW+4:2]];
      end
    endcase
  end

  // R4
  en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel(EN_CLR) |=> ((en & $past(wmask)) == '0));

  // R7
  miss_on_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit & sec) != '0) |=> ((miss & $past(hit & sec)) == $past(hit & sec)));

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !sel(SEC_CLR)) |=> (req_valid && $stable(req_chan) && $stable(req_slot)));

  // R9
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |=> pend[$past(cpl_code)]);

  // R5
  trig_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> req_valid);
endmodule

// File: tb/tb_qdma_trigger_map.sv
module tb_qdma_trigger_map;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [15:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [2:0]  req_chan;
  logic [8:0]  req_slot;
  logic        cpl_valid = 1'b0;
  logic [5:0]  cpl_code = '0;

  int errors = 0;
  int checks = 0;
  int expq[$];

  always #4 clk = ~clk;

  qdma_trigger_map dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_slot(req_slot), .cpl_valid(cpl_valid), .cpl_code(cpl_code));

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(string tag, logic [15:0] a, logic [31:0] exp);
    @(negedge clk);
    rd_addr = a;
    #1 check(tag, rd_data, exp);
  endtask

  task automatic expect_req(int ch, int slot);
    expq.push_back(ch * 1024 + slot);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && req_valid && req_ready) begin
      if (expq.size() == 0) begin
        check("R5 unexpected request", {20'h0, req_chan, req_slot}, 32'hFFFFFFFF);
      end else begin
        int e;
        e = expq.pop_front();
        check("R5/R8 request order", {20'h0, req_chan, req_slot},
              32'(((e / 1024) << 9) | (e % 1024)));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1
    rd("R1 enable", 16'h1080, 0);
    rd("R1 sec", 16'h1090, 0);
    rd("R1 miss", 16'h0310, 0);
    rd("R1 pend lo", 16'h1068, 0);
    rd("R1 pend hi", 16'h106C, 0);
    rd("R1 map0", 16'h0200, 0);
    check("R1 req_valid", {31'h0, req_valid}, 0);

    // R2
    wr(16'h0200, 32'hFFFF0000 | (3 << 5) | (5 << 2) | 3);
    rd("R2 map0", 16'h0200, 32'h74);
    wr(16'h021C, (511 << 5) | (7 << 2));
    rd("R2 map7", 16'h021C, 32'h3FFC);

    // R3
    wr(16'h4044, 32'hDEADBEEF);
    rd("R3 pram", 16'h4044, 32'hDEADBEEF);

    // R4
    wr(16'h108C, 32'h81);
    rd("R4 set", 16'h1080, 32'h81);
    wr(16'h108C, 32'h0);
    rd("R4 set zero", 16'h1080, 32'h81);
    wr(16'h1088, 32'h80);
    rd("R4 clear", 16'h1080, 32'h01);
    wr(16'h1088, 32'h0);
    rd("R4 clear zero", 16'h1080, 32'h01);

    // R5
    req_ready = 1'b1;
    expect_req(0, 3);
    wr(16'h4074, 32'h1234);
    idle(3);
    wr(16'h4070, 32'h1);
    idle(2);
    rd("R5 other word no event", 16'h1090, 0);
    wr(16'h0204, (4 << 5));
    wr(16'h4080, 32'h5);
    idle(2);
    rd("R5 disabled no event", 16'h1090, 0);
    check("R5 queue drained", 32'(expq.size()), 0);

    // R6 / R7
    req_ready = 1'b0;
    wr(16'h020C, (2 << 5) | (7 << 2));
    wr(16'h108C, 32'h08);
    expect_req(3, 2);
    wr(16'h405C, 32'h1);
    rd("R6 sec set", 16'h1090, 32'h08);
    check("R5 req chan", {29'h0, req_chan}, 3);
    check("R5 req slot", {23'h0, req_slot}, 2);
    wr(16'h405C, 32'h2);
    rd("R7 miss set", 16'h0310, 32'h08);
    rd("R7 sec still set", 16'h1090, 32'h08);
    wr(16'h0314, 32'h0);
    rd("R7 miss zero write", 16'h0310, 32'h08);
    req_ready = 1'b1;
    idle(3);
    req_ready = 1'b0;
    rd("R6 sec cleared by accept", 16'h1090, 0);
    check("R7 single request", 32'(expq.size()), 0);
    wr(16'h0314, 32'h08);
    rd("R7 miss cleared", 16'h0310, 0);
    wr(16'h405C, 32'h3);
    rd("R6 sec set again", 16'h1090, 32'h08);
    wr(16'h1094, 32'h08);
    rd("R6 sec w1c", 16'h1090, 0);
    check("R6 req dropped", {31'h0, req_valid}, 0);

    // R8
    wr(16'h0214, (6 << 5) | (1 << 2));
    wr(16'h0208, (9 << 5) | (3 << 2));
    wr(16'h108C, 32'h24);
    expect_req(5, 6);
    expect_req(2, 9);
    wr(16'h40C4, 32'h0);
    wr(16'h412C, 32'h0);
    idle(1);
    #1 check("R8 held first request", {29'h0, req_chan}, 5);
    req_ready = 1'b1;
    idle(4);
    req_ready = 1'b0;
    wr(16'h0218, (10 << 5));
    wr(16'h0204, (10 << 5));
    wr(16'h108C, 32'h42);
    expect_req(1, 10);
    expect_req(6, 10);
    wr(16'h4140, 32'h0);
    idle(1);
    #1 check("R8 lowest first", {29'h0, req_chan}, 1);
    req_ready = 1'b1;
    idle(4);
    check("R8 queue drained", 32'(expq.size()), 0);

    // R9
    @(negedge clk); cpl_valid = 1'b1; cpl_code = 6'd5;
    @(negedge clk); cpl_code = 6'd40;
    @(negedge clk); cpl_valid = 1'b0;
    rd("R9 pend lo", 16'h1068, 32'h20);
    rd("R9 pend hi", 16'h106C, 32'h100);

    // R10
    wr(16'h1070, 32'h20);
    rd("R10 clear lo", 16'h1068, 0);
    wr(16'h1074, 32'h0);
    rd("R10 zero write hi", 16'h106C, 32'h100);
    wr(16'h1074, 32'h100);
    rd("R10 clear hi", 16'h106C, 0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 16'h1070; wr_data = 32'h08;
    cpl_valid = 1'b1; cpl_code = 6'd3;
    @(negedge clk);
    wr_en = 1'b0; cpl_valid = 1'b0;
    rd("R10 set wins", 16'h1068, 32'h08);

    idle(2);
    check("R5 final queue empty", 32'(expq.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule